// File: doc/BRIEF.md
# Handheld Controller Report Decoder

This block listens without driving anything to a stream of I2C bus events that an upstream bit-level decoder has already produced: start, stop, address (with its read/write direction) and data byte. It rebuilds the reports that a two-button handheld motion controller returns on the bus. It also checks the short configuration write that a host sends to that controller.

On a read transaction the data bytes fill six register slots, selected by a running index. The slots hold the two analog stick positions and the upper eight bits of three accelerometer axes. A sixth byte packs the two buttons and the low two bits of each axis. When the stop arrives and all six slots have been filled during that transaction, the block emits a one-cycle report pulse with the stick values, the three 10-bit axes and active-high pressed flags. On a write transaction it keeps the first two bytes and counts all of them. At the stop it raises either an init-ok pulse or an init-error pulse with an error code.

Top module: `hcr_decoder`

## Requirements
- R1: After synchronous reset (`rst` high), `rpt_valid`, `init_ok` and `init_err` are low and the read index is 0.
- R2: The transaction controller leaves idle only on `ev_start`. In the address-wait state an address with `ev_addr_rd`=1 selects read handling and one with `ev_addr_rd`=0 selects write handling.
- R3: In read handling, data bytes at index 0, 1, 2, 3 and 4 load stick X, stick Y, and bits [9:2] of accelerometer X, Y and Z.
- R4: The byte at index 5 supplies the low accelerometer bits: bits [3:2] are X[1:0], bits [5:4] are Y[1:0] and bits [7:6] are Z[1:0]. Bit 0 is the Z button and bit 1 is the C button, both 0 when pressed. `rpt_btn_z` and `rpt_btn_c` are 1 when the button is pressed.
- R5: A stop in read handling pulses `rpt_valid` high for one cycle, in the cycle after the stop, only if all six indices were written since the transaction began. All received marks are then cleared and the controller returns to idle.
- R6: The read index advances by one per read data byte, wraps from 5 to 0, and is not reset by a stop, so a later read continues from where the earlier one stopped.
- R7: A stop in write handling after exactly two data bytes 0x40 then 0x00 pulses `init_ok` for one cycle, in the cycle after the stop.
- R8: A stop in write handling after any byte count other than two (including zero and more than two) pulses `init_err` with `init_err_code` = 1.
- R9: A stop in write handling after two bytes that differ from 0x40, 0x00 pulses `init_err` with `init_err_code` = 2.
- R10: Data and address events in idle, data and stop events while waiting for the address, and start and address events during read or write handling have no effect.
- R11: `rpt_valid`, `init_ok` and `init_err` are single-cycle pulses, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_start | input | 1 | Start condition strobe |
| ev_stop | input | 1 | Stop condition strobe |
| ev_addr | input | 1 | Address byte strobe |
| ev_addr_rd | input | 1 | Direction of the address strobe, 1 = read |
| ev_data | input | 1 | Data byte strobe |
| ev_byte | input | 8 | Data byte value |
| rpt_valid | output | 1 | Report pulse |
| rpt_stick_x | output | 8 | Stick X position |
| rpt_stick_y | output | 8 | Stick Y position |
| rpt_acc_x | output | 10 | Accelerometer X |
| rpt_acc_y | output | 10 | Accelerometer Y |
| rpt_acc_z | output | 10 | Accelerometer Z |
| rpt_btn_z | output | 1 | Z button pressed |
| rpt_btn_c | output | 1 | C button pressed |
| init_ok | output | 1 | Correct configuration write seen |
| init_err | output | 1 | Bad configuration write seen |
| init_err_code | output | 2 | 1 = wrong length, 2 = wrong value |

## Verification
The assertions check on every cycle the properties that depend only on timing. Every pulse follows a stop by exactly one cycle, the pulses stay exclusive and short, the controller keeps idle until a start, the address direction picks the right handling, the read index stays in range, and error codes take only legal values. Only the bench's scenarios can show the actual values. These include the placement of bits from the packed sixth byte, the inverted button sense, and a report rebuilt after the index wraps across two transactions. They also include the separate length and value error codes, and the silence that follows partial reads and ignored events.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
  localparam int BYTE_W    = 8;
  localparam int ACC_W     = BYTE_W + 2;
  localparam int NUM_AXES  = 3;
  localparam int NUM_BYTES = 6;
  localparam int IDX_W     = $clog2(NUM_BYTES);
  localparam int IDX_LAST  = NUM_BYTES - 1;
  localparam int IDX_ACC0  = 2;
  localparam int CNT_W     = 2;
  localparam int INIT_LEN  = 2;
  localparam logic [BYTE_W-1:0] INIT_B0 = 8'h40;
  localparam logic [BYTE_W-1:0] INIT_B1 = 8'h00;

  localparam logic [1:0] ERR_LEN = 2'd1;
  localparam logic [1:0] ERR_VAL = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_READ  = 2'd2,
    ST_WRITE = 2'd3
  } hcr_state_e;

  // Pull the two low bits for one axis out of the packed last byte.
  function automatic logic [1:0] low_pair(input logic [BYTE_W-1:0] b, input int axis);
    return b[2 + 2*axis +: 2];
  endfunction

  // Join an upper byte and a low bit pair into a full axis value.
  function automatic logic [ACC_W-1:0] acc_join(input logic [BYTE_W-1:0] hi, input logic [1:0] lo);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/hcr_ctrl.sv
module hcr_ctrl
  import hcr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic       ev_addr,
  input  logic       ev_addr_rd,
  input  logic       ev_data,
  output hcr_state_e state_o,
  output logic       rd_byte,
  output logic       rd_stop,
  output logic       wr_byte,
  output logic       wr_stop
);
  hcr_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (ev_start) st_d = ST_ADDR;
      ST_ADDR:  if (ev_addr)  st_d = ev_addr_rd ? ST_READ : ST_WRITE;
      ST_READ,
      ST_WRITE: if (ev_stop)  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  assign state_o = st_q;
  assign rd_byte = (st_q == ST_READ)  && ev_data;
  assign rd_stop = (st_q == ST_READ)  && ev_stop;
  assign wr_byte = (st_q == ST_WRITE) && ev_data;
  assign wr_stop = (st_q == ST_WRITE) && ev_stop;
endmodule

// File: rtl/hcr_read_asm.sv
module hcr_read_asm
  import hcr_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd_byte,
  input  logic                   rd_stop,
  input  logic [BYTE_W-1:0]      byte_i,
  output logic [IDX_W-1:0]       idx_o,
  output logic                   rpt_valid,
  output logic [BYTE_W-1:0]      stick_x,
  output logic [BYTE_W-1:0]      stick_y,
  output logic [NUM_AXES-1:0][ACC_W-1:0] acc,
  output logic                   btn_z,
  output logic                   btn_c
);
  logic [IDX_W-1:0]                  idx_q;
  logic [NUM_BYTES-1:0]              seen_q;
  logic [BYTE_W-1:0]                 sx_q, sy_q, lo_q;
  logic [NUM_AXES-1:0][BYTE_W-1:0]   hi_q;
  logic                              rpt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      seen_q <= '0;
      sx_q   <= '0;
      sy_q   <= '0;
      lo_q   <= '1;
      hi_q   <= '0;
      rpt_q  <= 1'b0;
    end else begin
      rpt_q <= rd_stop && (&seen_q);
      if (rd_stop) begin
        seen_q <= '0;
      end else if (rd_byte) begin
        seen_q[idx_q] <= 1'b1;
        idx_q <= (idx_q == IDX_W'(IDX_LAST)) ? '0 : idx_q + 1'b1;
        if (idx_q == IDX_W'(0)) sx_q <= byte_i;
        if (idx_q == IDX_W'(1)) sy_q <= byte_i;
        if (idx_q == IDX_W'(IDX_LAST)) lo_q <= byte_i;
        for (int a = 0; a < NUM_AXES; a++) begin
          if (idx_q == IDX_W'(IDX_ACC0 + a)) hi_q[a] <= byte_i;
        end
      end
    end
  end

  for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
    assign acc[a] = acc_join(hi_q[a], low_pair(lo_q, a));
  end

  assign idx_o     = idx_q;
  assign rpt_valid = rpt_q;
  assign stick_x   = sx_q;
  assign stick_y   = sy_q;
  assign btn_z     = ~lo_q[0];
  assign btn_c     = ~lo_q[1];
endmodule

// File: rtl/hcr_init_chk.sv
module hcr_init_chk
  import hcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_byte,
  input  logic              wr_stop,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              ok_o,
  output logic              err_o,
  output logic [1:0]        code_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] b0_q, b1_q;
  logic              ok_q, err_q;
  logic [1:0]        code_q;
  logic              len_bad, val_bad;

  assign len_bad = (cnt_q != CNT_W'(INIT_LEN));
  assign val_bad = (b0_q != INIT_B0) || (b1_q != INIT_B1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      b0_q   <= '0;
      b1_q   <= '0;
      ok_q   <= 1'b0;
      err_q  <= 1'b0;
      code_q <= '0;
    end else begin
      ok_q  <= 1'b0;
      err_q <= 1'b0;
      if (wr_stop) begin
        if (len_bad) begin
          err_q  <= 1'b1;
          code_q <= ERR_LEN;
        end else if (val_bad) begin
          err_q  <= 1'b1;
          code_q <= ERR_VAL;
        end else begin
          ok_q <= 1'b1;
        end
        cnt_q <= '0;
        b0_q  <= '0;
        b1_q  <= '0;
      end else if (wr_byte) begin
        if (cnt_q == CNT_W'(0)) b0_q <= byte_i;
        if (cnt_q == CNT_W'(1)) b1_q <= byte_i;
        if (cnt_q != CNT_MAX)   cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign ok_o   = ok_q;
  assign err_o  = err_q;
  assign code_o = code_q;
endmodule

// File: rtl/hcr_decoder.sv
module hcr_decoder
  import hcr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        ev_start,
  input  logic        ev_stop,
  input  logic        ev_addr,
  input  logic        ev_addr_rd,
  input  logic        ev_data,
  input  logic [7:0]  ev_byte,
  output logic        rpt_valid,
  output logic [7:0]  rpt_stick_x,
  output logic [7:0]  rpt_stick_y,
  output logic [9:0]  rpt_acc_x,
  output logic [9:0]  rpt_acc_y,
  output logic [9:0]  rpt_acc_z,
  output logic        rpt_btn_z,
  output logic        rpt_btn_c,
  output logic        init_ok,
  output logic        init_err,
  output logic [1:0]  init_err_code
);
  hcr_state_e ctrl_state;
  logic       rd_byte, rd_stop, wr_byte, wr_stop;
  logic [IDX_W-1:0] rd_idx;
  logic [NUM_AXES-1:0][ACC_W-1:0] acc_w;

  hcr_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_addr(ev_addr),
    .ev_addr_rd(ev_addr_rd), .ev_data(ev_data),
    .state_o(ctrl_state),
    .rd_byte(rd_byte), .rd_stop(rd_stop), .wr_byte(wr_byte), .wr_stop(wr_stop)
  );

  hcr_read_asm u_rd (
    .clk(clk), .rst(rst), .rd_byte(rd_byte), .rd_stop(rd_stop), .byte_i(ev_byte),
    .idx_o(rd_idx), .rpt_valid(rpt_valid),
    .stick_x(rpt_stick_x), .stick_y(rpt_stick_y), .acc(acc_w),
    .btn_z(rpt_btn_z), .btn_c(rpt_btn_c)
  );

  hcr_init_chk u_init (
    .clk(clk), .rst(rst), .wr_byte(wr_byte), .wr_stop(wr_stop), .byte_i(ev_byte),
    .ok_o(init_ok), .err_o(init_err), .code_o(init_err_code)
  );

  assign rpt_acc_x = acc_w[0];
  assign rpt_acc_y = acc_w[1];
  assign rpt_acc_z = acc_w[2];
endmodule

// File: rtl/hcr_decoder_chk.sv
module hcr_decoder_chk
  import hcr_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             ev_start,
  input logic             ev_stop,
  input logic             ev_addr,
  input logic             ev_addr_rd,
  input hcr_state_e       state,
  input logic [IDX_W-1:0] rd_idx,
  input logic             rpt_valid,
  input logic             init_ok,
  input logic             init_err,
  input logic [1:0]       init_err_code
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rpt_valid && !init_ok && !init_err && rd_idx == '0)); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !ev_start) |=> (state == ST_IDLE)); // R2
  AST_ADDR_RD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADDR && ev_addr && ev_addr_rd) |=> (state == ST_READ)); // R2
  AST_ADDR_WR: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADDR && ev_addr && !ev_addr_rd) |=> (state == ST_WRITE)); // R2
  AST_RPT_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
    $rose(rpt_valid) |-> $past(ev_stop && state == ST_READ)); // R5
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    rd_idx <= IDX_W'(IDX_LAST)); // R6
  AST_OK_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
    $rose(init_ok) |-> $past(ev_stop && state == ST_WRITE)); // R7
  AST_ERR_CODE: assert property (@(posedge clk) disable iff (rst)
    init_err |-> (init_err_code == ERR_LEN || init_err_code == ERR_VAL)); // R8
  AST_RW_IGNORE_START: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_READ || state == ST_WRITE) && !ev_stop) |=> $stable(state)); // R10
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rpt_valid, init_ok, init_err})); // R11
  AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (rst)
    (rpt_valid || init_ok || init_err) |=> !(rpt_valid || init_ok || init_err)); // R11
endmodule

bind hcr_decoder hcr_decoder_chk chk_i (
  .clk(clk), .rst(rst), .ev_start(ev_start), .ev_stop(ev_stop),
  .ev_addr(ev_addr), .ev_addr_rd(ev_addr_rd), .state(ctrl_state), .rd_idx(rd_idx),
  .rpt_valid(rpt_valid), .init_ok(init_ok), .init_err(init_err),
  .init_err_code(init_err_code)
);

// File: tb/hcr_decoder_tb_top.sv
module hcr_decoder_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_start = 0, ev_stop = 0, ev_addr = 0, ev_addr_rd = 0, ev_data = 0;
  logic [7:0] ev_byte = '0;
  logic rpt_valid, rpt_btn_z, rpt_btn_c, init_ok, init_err;
  logic [7:0] rpt_stick_x, rpt_stick_y;
  logic [9:0] rpt_acc_x, rpt_acc_y, rpt_acc_z;
  logic [1:0] init_err_code;

  always #(CLK_PERIOD/2) clk = ~clk;

  hcr_decoder dut_i (
    .clk(clk), .rst(rst), .ev_start(ev_start), .ev_stop(ev_stop), .ev_addr(ev_addr),
    .ev_addr_rd(ev_addr_rd), .ev_data(ev_data), .ev_byte(ev_byte),
    .rpt_valid(rpt_valid), .rpt_stick_x(rpt_stick_x), .rpt_stick_y(rpt_stick_y),
    .rpt_acc_x(rpt_acc_x), .rpt_acc_y(rpt_acc_y), .rpt_acc_z(rpt_acc_z),
    .rpt_btn_z(rpt_btn_z), .rpt_btn_c(rpt_btn_c), .init_ok(init_ok),
    .init_err(init_err), .init_err_code(init_err_code)
  );

  typedef struct {
    int         kind;   // 0 report, 1 init ok, 2 init error
    logic [7:0] sx, sy;
    logic [9:0] ax, ay, az;
    logic       bz, bc;
    logic [1:0] code;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // Bench model of the read slots
  int         m_idx = 0;
  bit         m_got [6];
  logic [7:0] m_val [6];
  int         m_wcnt = 0;
  logic [7:0] m_w [2];

  function automatic logic [9:0] axis_of(logic [7:0] hi, logic [7:0] packed_b, int a);
    return 10'(hi) * 10'd4 + 10'((packed_b >> (2 + 2*a)) & 8'h03);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic strobe(input int kind, input logic [7:0] b, input logic rd);
    @(negedge clk);
    case (kind)
      0: ev_start = 1;
      1: ev_stop = 1;
      2: begin ev_addr = 1; ev_addr_rd = rd; end
      default: begin ev_data = 1; ev_byte = b; end
    endcase
    @(negedge clk);
    ev_start = 0; ev_stop = 0; ev_addr = 0; ev_data = 0;
  endtask

  // Read data byte: model follows R3/R6 index mapping
  task automatic rd_data(input logic [7:0] b);
    m_got[m_idx] = 1; m_val[m_idx] = b;
    m_idx = (m_idx == 5) ? 0 : m_idx + 1;
    strobe(3, b, 0);
  endtask

  task automatic rd_stop(input string req);
    bit all = 1;
    exp_t e;
    for (int i = 0; i < 6; i++) all &= m_got[i];
    if (all) begin
      e.kind = 0; e.sx = m_val[0]; e.sy = m_val[1];
      e.ax = axis_of(m_val[2], m_val[5], 0);
      e.ay = axis_of(m_val[3], m_val[5], 1);
      e.az = axis_of(m_val[4], m_val[5], 2);
      e.bz = (m_val[5] & 8'h01) == 0; e.bc = (m_val[5] & 8'h02) == 0;
      e.code = 0; e.req = req;
      exp_q.push_back(e);
    end
    for (int i = 0; i < 6; i++) m_got[i] = 0;
    strobe(1, 0, 0);
  endtask

  task automatic wr_data(input logic [7:0] b);
    if (m_wcnt < 2) m_w[m_wcnt] = b;
    m_wcnt++;
    strobe(3, b, 0);
  endtask

  task automatic wr_stop(input string req);
    exp_t e;
    e = '{kind: 1, sx: 0, sy: 0, ax: 0, ay: 0, az: 0, bz: 0, bc: 0, code: 0, req: req};
    if (m_wcnt != 2) begin e.kind = 2; e.code = 2'd1; end
    else if (m_w[0] != 8'h40 || m_w[1] != 8'h00) begin e.kind = 2; e.code = 2'd2; end
    exp_q.push_back(e);
    m_wcnt = 0;
    strobe(1, 0, 0);
  endtask

  task automatic rd_txn(input logic [7:0] bytes [], input string req);
    strobe(0, 0, 0); strobe(2, 0, 1);
    foreach (bytes[i]) rd_data(bytes[i]);
    rd_stop(req);
  endtask

  task automatic wr_txn(input logic [7:0] bytes [], input string req);
    strobe(0, 0, 0); strobe(2, 0, 0);
    foreach (bytes[i]) wr_data(bytes[i]);
    wr_stop(req);
  endtask

  task automatic quiet_chk(input string req);
    bit bad = 0;
    repeat (2) begin
      @(negedge clk);
      if (rpt_valid || init_ok || init_err) bad = 1;
    end
    n_chk++;
    if (bad) begin
      n_bad++;
      $display("FAIL %s: pulse seen, expected none (rpt=%0b ok=%0b err=%0b)", req, rpt_valid, init_ok, init_err);
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && (rpt_valid || init_ok || init_err)) begin
      exp_t e;
      n_chk++;
      if ($countones({rpt_valid, init_ok, init_err}) > 1) begin
        n_bad++;
        $display("FAIL R11: several pulses rpt=%0b ok=%0b err=%0b, expected one", rpt_valid, init_ok, init_err);
      end else if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R5/R7: unexpected pulse rpt=%0b ok=%0b err=%0b, expected none", rpt_valid, init_ok, init_err);
      end else begin
        e = exp_q.pop_front();
        if (e.kind == 0) begin
          if (!rpt_valid || rpt_stick_x != e.sx || rpt_stick_y != e.sy || rpt_acc_x != e.ax ||
              rpt_acc_y != e.ay || rpt_acc_z != e.az || rpt_btn_z != e.bz || rpt_btn_c != e.bc) begin
            n_bad++;
            $display("FAIL %s: got v=%0b %h %h %h %h %h z%0b c%0b, expected %h %h %h %h %h z%0b c%0b", e.req,
                     rpt_valid, rpt_stick_x, rpt_stick_y, rpt_acc_x, rpt_acc_y, rpt_acc_z, rpt_btn_z, rpt_btn_c,
                     e.sx, e.sy, e.ax, e.ay, e.az, e.bz, e.bc);
          end
        end else if (e.kind == 1) begin
          if (!init_ok) begin
            n_bad++;
            $display("FAIL %s: got ok=%0b err=%0b code=%0d, expected init_ok", e.req, init_ok, init_err, init_err_code);
          end
        end else begin
          if (!init_err || init_err_code != e.code) begin
            n_bad++;
            $display("FAIL %s: got err=%0b code=%0d, expected err code %0d", e.req, init_err, init_err_code, e.code);
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    @(negedge clk);
    n_chk++;
    if (rpt_valid || init_ok || init_err) begin
      n_bad++;
      $display("FAIL R1: pulses %0b%0b%0b after reset, expected 000", rpt_valid, init_ok, init_err);
    end

    // R3 R4 R5: plain read, Z pressed
    rd_txn('{8'h12, 8'h34, 8'hAB, 8'hCD, 8'hEF, 8'h9E}, "R3/R4 read pattern A");
    // R4: C pressed, Z released, other low bits
    rd_txn('{8'h00, 8'hFF, 8'h80, 8'h01, 8'h7F, 8'h65}, "R4 read pattern B");
    rd_txn('{8'h5A, 8'hA5, 8'h00, 8'hFF, 8'h3C, 8'h00}, "R4 both pressed");

    // R5: partial read gives no report
    rd_txn('{8'h11, 8'h22, 8'h33}, "R5 partial");
    quiet_chk("R5 partial read");
    // R6: index continues at 3, wraps, and all six slots fill
    rd_txn('{8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'hE5, 8'hF6}, "R6 wrapped read");
    rd_txn('{8'h01, 8'h02, 8'h03}, "R6 finish to wrap");
    quiet_chk("R6 partial tail");
    rd_txn('{8'h44, 8'h55, 8'h66, 8'h77, 8'h88, 8'hFF}, "R6 realigned read");

    // R10: events in idle and address-wait ignored
    strobe(3, 8'hEE, 0); strobe(2, 0, 1); strobe(1, 0, 0);
    quiet_chk("R10 idle events");
    strobe(0, 0, 0); strobe(3, 8'hEE, 0); strobe(1, 0, 0); strobe(2, 0, 1);
    for (int i = 0; i < 3; i++) rd_data(8'h10 + 8'(i));
    strobe(0, 0, 0); strobe(2, 0, 0);          // R10 start/address inside read ignored
    for (int i = 3; i < 6; i++) rd_data(8'h10 + 8'(i));
    rd_stop("R10 read with ignored events");

    // R2: write selected by direction, R7 good init
    wr_txn('{8'h40, 8'h00}, "R7 good init");
    // R8 length errors
    wr_txn('{8'h40}, "R8 one byte");
    wr_txn('{8'h40, 8'h00, 8'h00}, "R8 three bytes");
    wr_txn('{8'h40, 8'h00, 8'h00, 8'h00, 8'h12}, "R8 five bytes");
    strobe(0, 0, 0); strobe(2, 0, 0); wr_stop("R8 zero bytes");
    // R9 value errors
    wr_txn('{8'h41, 8'h00}, "R9 bad first");
    wr_txn('{8'h40, 8'h01}, "R9 bad second");
    // R10: start inside write ignored, then still ok
    strobe(0, 0, 0); strobe(2, 0, 0); wr_data(8'h40); strobe(0, 0, 0);
    strobe(2, 0, 1); wr_data(8'h00); wr_stop("R10 write with ignored events");
    // R2: read after writes
    rd_txn('{8'hC0, 8'h0C, 8'h99, 8'h66, 8'h33, 8'hA9}, "R2 read after write");

    repeat (4) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R5/R7: %0d expected pulses missing, expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule